// File: doc/BRIEF.md
# Clock Holdover History Averager

This block sits between a digital PLL's loop filter and its oscillator. While at least one reference input is usable, it passes each frequency control word through to the oscillator and records it in a circular history. From that history it keeps a running mean over a window of samples. The window ends a programmable number of samples before the newest one, so disturbances in the last moments before a reference failure stay out of the mean.

When every monitored input is flagged unusable, the block stops tracking. If the history is complete, it enters holdover. It first keeps the last applied word, then steps it gradually toward the stored mean. If the history is incomplete, it freezes on the last word instead. Tracking resumes as soon as any input is usable again, and the history is rebuilt from empty.

Both the delay and the averaging length are 5-bit codes. Each code selects a span of 2^code samples, clamped to half the buffer depth.

Top module: `hold_hist_ctrl`

## Requirements
- R1: An input is unusable when its loss flag is set or, with fault qualification enabled (FOS_USE=1), its frequency-fault flag is set. Holdover starts only when every input is unusable.
- R2: With FOS_USE=0, the frequency-fault flags have no effect, and only loss flags on all inputs start holdover.
- R3: In tracking mode (mode code 0), a strobed control word appears on `cw_out` one clock after the strobe. After reset, `cw_out` is 0, `mode` is 0 and `hist_valid` is 0.
- R4: A delay or averaging code c selects a span of 2^min(c, DEPTH_LG2-1) samples.
- R5: `hist_valid` is high when the number of samples recorded since the history was last cleared is at least the delay span plus the averaging span. The history is cleared whenever either code changes, and `hist_valid` reads 0 the cycle after the change.
- R6: The holdover target is the floor of the mean of the samples whose age (0 = newest) runs from the delay span to the delay span plus the averaging span minus 1, taken at holdover entry.
- R7: On entry with valid history, `mode` becomes 1 (holdover) and `cw_out` keeps its last value for RAMP_DIV-1 further clocks.
- R8: In holdover, every RAMP_DIV clocks `cw_out` moves toward the target by |target - cw_out| >> 4. When that step is 0, `cw_out` is set equal to the target.
- R9: On entry without valid history, `mode` becomes 2 (freeze) and `cw_out` stays constant for the whole freeze.
- R10: Control words strobed while all inputs are unusable, including in the entry cycle, do not reach `cw_out`.
- R11: Once any input is usable in holdover or freeze, `mode` returns to 0 on the next clock, `cw_out` keeps its value until the next strobe, and the history restarts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Strobe marking a new control word |
| cw_in | input | CW_W | Control word from the loop filter |
| los | input | NUM_IN | Per-input loss-of-signal flags |
| fos | input | NUM_IN | Per-input frequency-fault flags |
| del_code | input | 5 | Delay code, span 2^code samples |
| avg_code | input | 5 | Averaging code, span 2^code samples |
| cw_out | output | CW_W | Control word applied to the oscillator |
| mode | output | 2 | 0 tracking, 1 holdover, 2 freeze |
| hist_valid | output | 1 | History long enough for holdover |

## Verification
The main instance is built with DEPTH_LG2=5 and RAMP_DIV=3. A 32-entry ring lets codes above 4 hit the clamp, and a full-ring window whose oldest sample is overwritten on the same clock, within a few dozen samples. With a three-clock step interval, a ramp across the full 16-bit range settles in a few hundred cycles. A second instance with NUM_IN=2 and FOS_USE=0 exercises the loss-only entry rule.

// File: rtl/hhc_pkg.sv
package hhc_pkg;

  typedef enum logic [1:0] {
    MODE_TRACK  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_FREEZE = 2'd2
  } hold_mode_e;

  function automatic logic [4:0] clamp_code(input logic [4:0] code, input logic [4:0] limit);
    return (code > limit) ? limit : code;
  endfunction

endpackage

// File: rtl/hhc_loss.sv
module hhc_loss #(
  parameter int NUM_IN  = 4,
  parameter bit FOS_USE = 1'b1
) (
  input  logic [NUM_IN-1:0] los,
  input  logic [NUM_IN-1:0] fos,
  output logic              all_bad
);

  logic [NUM_IN-1:0] unusable;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    if (FOS_USE) begin : g_q
      assign unusable[i] = los[i] | fos[i];
    end else begin : g_l
      assign unusable[i] = los[i];
    end

    // R1
    always_comb begin
      if (all_bad) begin
        input_flagged_chk: assert (los[i] || (FOS_USE && fos[i]));
      end
    end
  end

  assign all_bad = &unusable;

endmodule

// File: rtl/hhc_window.sv
module hhc_window #(
  parameter int CW_W      = 16,
  parameter int DEPTH_LG2 = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic            clr,
  input  logic [CW_W-1:0] cw_in,
  input  logic [4:0]      del_code,
  input  logic [4:0]      avg_code,
  output logic            hist_valid,
  output logic [CW_W-1:0] avg
);
  import hhc_pkg::*;

  localparam int AW    = DEPTH_LG2;
  localparam int DEPTH = 1 << AW;
  localparam int SUMW  = CW_W + AW;
  localparam logic [4:0] MAXC = 5'(AW - 1);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [CW_W-1:0] mem [DEPTH];
  logic [AW-1:0]   wp_q, in_addr, out_addr;
  logic [AW:0]     fill_q, dspan, aspan;
  logic [AW+1:0]   need;
  logic [SUMW-1:0] sum_q, add_v, sub_v;
  logic [4:0]      dq, aq, dcl, acl;
  logic            chg, we, add_en, sub_en;

  assign dcl   = clamp_code(dq, MAXC);
  assign acl   = clamp_code(aq, MAXC);
  assign dspan = {{AW{1'b0}}, 1'b1} << dcl;
  assign aspan = {{AW{1'b0}}, 1'b1} << acl;
  assign need  = {1'b0, dspan} + {1'b0, aspan};
  assign chg   = (del_code != dq) || (avg_code != aq);
  assign we    = wr_req && !chg && !clr;

  assign in_addr  = wp_q - dspan[AW-1:0];
  assign out_addr = wp_q - dspan[AW-1:0] - aspan[AW-1:0];
  assign add_en   = fill_q >= dspan;
  assign sub_en   = {1'b0, fill_q} >= need;
  assign add_v    = add_en ? SUMW'(mem[in_addr])  : '0;
  assign sub_v    = sub_en ? SUMW'(mem[out_addr]) : '0;

  always_ff @(posedge clk) begin
    if (we) mem[wp_q] <= cw_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      fill_q <= '0;
      sum_q  <= '0;
      dq     <= '0;
      aq     <= '0;
    end else begin
      dq <= del_code;
      aq <= avg_code;
      if (clr || chg) begin
        fill_q <= '0;
        sum_q  <= '0;
      end else if (we) begin
        wp_q   <= wp_q + 1'b1;
        fill_q <= (fill_q == FULL) ? fill_q : fill_q + 1'b1;
        sum_q  <= sum_q + add_v - sub_v;
      end
    end
  end

  assign hist_valid = {1'b0, fill_q} >= need;
  assign avg        = CW_W'(sum_q >> acl);

  // R5
  hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr || chg) |=> !hist_valid);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (fill_q != '0));

endmodule

// File: rtl/hhc_fsm.sv
module hhc_fsm #(
  parameter int CW_W     = 16,
  parameter int RAMP_DIV = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            all_bad,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw_in,
  input  logic            hist_valid,
  input  logic [CW_W-1:0] avg,
  output logic [CW_W-1:0] cw_out,
  output logic [1:0]      mode_o,
  output logic            wr_req,
  output logic            clr
);
  import hhc_pkg::*;

  localparam int CNTW = $clog2(RAMP_DIV);
  localparam logic [CNTW-1:0] LAST = CNTW'(RAMP_DIV - 1);

  hold_mode_e          mode_q;
  logic [CW_W-1:0]     cw_q, tgt_q, stp, ramp_nx;
  logic [CNTW-1:0]     cnt_q;
  logic signed [CW_W:0] diff;
  logic [CW_W:0]       mag;

  always_comb begin
    diff = $signed({1'b0, tgt_q}) - $signed({1'b0, cw_q});
    mag  = diff[CW_W] ? $unsigned(-diff) : $unsigned(diff);
    stp  = CW_W'(mag >> 4);
    if (stp == '0)       ramp_nx = tgt_q;
    else if (diff[CW_W]) ramp_nx = cw_q - stp;
    else                 ramp_nx = cw_q + stp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_TRACK;
      cw_q   <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (mode_q)
        MODE_TRACK: begin
          if (all_bad) begin
            cnt_q  <= '0;
            tgt_q  <= avg;
            mode_q <= hist_valid ? MODE_HOLD : MODE_FREEZE;
          end else if (cw_valid) begin
            cw_q <= cw_in;
          end
        end
        MODE_HOLD: begin
          if (!all_bad) begin
            mode_q <= MODE_TRACK;
          end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            cw_q  <= ramp_nx;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        MODE_FREEZE: begin
          if (!all_bad) mode_q <= MODE_TRACK;
        end
        default: mode_q <= MODE_TRACK;
      endcase
    end
  end

  assign cw_out = cw_q;
  assign mode_o = mode_q;
  assign wr_req = (mode_q == MODE_TRACK) && cw_valid && !all_bad;
  assign clr    = (mode_q != MODE_TRACK) && !all_bad;

  // R3
  track_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TRACK && cw_valid && !all_bad) |=> (cw_out == $past(cw_in)));

  // R7
  entry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TRACK && all_bad) |=> ($stable(cw_out) && mode_o != 2'd0));

  // R8
  ramp_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_HOLD && all_bad && cw_q <= tgt_q) |=> (cw_q <= tgt_q && $stable(tgt_q)));

  // R9
  freeze_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FREEZE && all_bad) |=> ($stable(cw_out) && mode_o == 2'd2));

  // R11
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_TRACK && !all_bad) |=> (mode_o == 2'd0 && !hist_valid));

endmodule

// File: rtl/hold_hist_ctrl.sv
module hold_hist_ctrl #(
  parameter int CW_W      = 16,
  parameter int NUM_IN    = 4,
  parameter bit FOS_USE   = 1'b1,
  parameter int DEPTH_LG2 = 5,
  parameter int RAMP_DIV  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_valid,
  input  logic [CW_W-1:0]   cw_in,
  input  logic [NUM_IN-1:0] los,
  input  logic [NUM_IN-1:0] fos,
  input  logic [4:0]        del_code,
  input  logic [4:0]        avg_code,
  output logic [CW_W-1:0]   cw_out,
  output logic [1:0]        mode,
  output logic              hist_valid
);

  logic            all_bad, wr_req, clr;
  logic [CW_W-1:0] avg;

  hhc_loss #(.NUM_IN(NUM_IN), .FOS_USE(FOS_USE)) u_loss (
    .los(los), .fos(fos), .all_bad(all_bad)
  );

  hhc_window #(.CW_W(CW_W), .DEPTH_LG2(DEPTH_LG2)) u_win (
    .clk(clk), .rst(rst), .wr_req(wr_req), .clr(clr), .cw_in(cw_in),
    .del_code(del_code), .avg_code(avg_code),
    .hist_valid(hist_valid), .avg(avg)
  );

  hhc_fsm #(.CW_W(CW_W), .RAMP_DIV(RAMP_DIV)) u_fsm (
    .clk(clk), .rst(rst), .all_bad(all_bad), .cw_valid(cw_valid),
    .cw_in(cw_in), .hist_valid(hist_valid), .avg(avg),
    .cw_out(cw_out), .mode_o(mode), .wr_req(wr_req), .clr(clr)
  );

endmodule

// File: tb/hold_hist_ctrl_test.sv
module hold_hist_ctrl_test;

  localparam int L   = 5;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cw_valid = 1'b0;
  logic [15:0] cw_in = '0;
  logic [3:0]  los = '0, fos = '0;
  logic [1:0]  los_v = '0, fos_v = '0;
  logic [4:0]  dc = '0, ac = '0;
  logic [15:0] cw_out, cw_out_v;
  logic [1:0]  mode, mode_v;
  logic        hv, hv_v;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [15:0] hm [64];
  int m_wp = 0, m_fill = 0, m_dq = 0, m_aq = 0, m_mode = 0, m_cnt = 0;
  int m_cw = 0, m_tgt = 0;
  bit m_hv = 0;

  always #2 clk = ~clk;

  hold_hist_ctrl #(.CW_W(16), .NUM_IN(4), .FOS_USE(1'b1), .DEPTH_LG2(L), .RAMP_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_in(cw_in), .los(los), .fos(fos),
    .del_code(dc), .avg_code(ac), .cw_out(cw_out), .mode(mode), .hist_valid(hv)
  );

  hold_hist_ctrl #(.CW_W(16), .NUM_IN(2), .FOS_USE(1'b0), .DEPTH_LG2(L), .RAMP_DIV(DIV)) uut_v (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_in(cw_in), .los(los_v), .fos(fos_v),
    .del_code(dc), .avg_code(ac), .cw_out(cw_out_v), .mode(mode_v), .hist_valid(hv_v)
  );

  function automatic int spn(input int c);
    return 1 << ((c > L - 1) ? L - 1 : c);
  endfunction

  function automatic int model_avg();
    int s = 0;
    int d = spn(m_dq);
    int a = spn(m_aq);
    for (int k = d; k < d + a; k++) s += hm[(m_wp - 1 - k) & 63];
    return s / a;
  endfunction

  function automatic int ramp(input int cur, input int tgt);
    int df = tgt - cur;
    int mg = (df < 0) ? -df : df;
    int st = mg >> 4;
    if (st == 0) return tgt;
    return (df < 0) ? cur - st : cur + st;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit bad = 1'b1;
    bit chg;
    bit phv;
    int av;
    for (int i = 0; i < 4; i++) bad &= (los[i] | fos[i]);
    chg = (int'(dc) != m_dq) || (int'(ac) != m_aq);
    phv = m_fill >= spn(m_dq) + spn(m_aq);
    av  = phv ? model_avg() : 0;
    case (m_mode)
      0: begin
        if (bad) begin
          m_cnt = 0; m_tgt = av; m_mode = phv ? 1 : 2;
        end else if (cw_valid) begin
          m_cw = cw_in;
          if (!chg) begin
            hm[m_wp & 63] = cw_in; m_wp++;
            m_fill = (m_fill == 32) ? 32 : m_fill + 1;
          end
        end
      end
      1: begin
        if (!bad) begin m_mode = 0; m_fill = 0; end
        else if (m_cnt == DIV - 1) begin m_cnt = 0; m_cw = ramp(m_cw, m_tgt); end
        else m_cnt++;
      end
      default: begin
        if (!bad) begin m_mode = 0; m_fill = 0; end
      end
    endcase
    if (chg) m_fill = 0;
    m_dq = dc; m_aq = ac;
    m_hv = m_fill >= spn(m_dq) + spn(m_aq);
  endtask

  task automatic compare();
    string t = (m_mode == 0) ? "R3" : (m_mode == 1) ? "R8" : "R9";
    check(cw_out == 16'(m_cw), t, cw_out, m_cw);
    check(mode == 2'(m_mode), "R7", mode, m_mode);
    check(hv == m_hv, "R5", hv, m_hv);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst) model_edge();
    @(negedge clk);
    if (!rst) compare();
  endtask

  task automatic push(input int v);
    cw_valid = 1'b1; cw_in = 16'(v); cyc(); cw_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int last;
    int rv;
    bit lost = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, R3
    check(cw_out == 16'd0 && mode == 2'd0 && hv == 1'b0, "R3", {cw_out, mode, hv}, 0);

    // history fill with 4 + 4 spans, R5
    dc = 5'd2; ac = 5'd2; cyc();
    for (int i = 0; i < 7; i++) push(1000 + 16 * i);
    check(hv == 1'b0, "R5", hv, 0);
    push(1000 + 16 * 7);
    check(hv == 1'b1, "R5", hv, 1);
    for (int i = 0; i < 4; i++) push(5000);

    // entry with valid history, R7 / R10
    los = 4'hF; cw_valid = 1'b1; cw_in = 16'd777; cyc();
    check(mode == 2'd1 && cw_out == 16'd5000, "R7", cw_out, 5000);
    cw_in = 16'd9999; cyc(); cyc();
    check(cw_out == 16'd5000, "R7", cw_out, 5000);
    cyc();
    check(cw_out == 16'(ramp(5000, 1088)), "R8", cw_out, ramp(5000, 1088));
    check(cw_out != 16'd9999, "R10", cw_out, ramp(5000, 1088));
    cw_valid = 1'b0;
    repeat (600) cyc();
    check(cw_out == 16'd1088, "R6", cw_out, 1088);

    // resume, R11
    los = 4'hB; cyc();
    check(mode == 2'd0 && hv == 1'b0 && cw_out == 16'd1088, "R11", mode, 0);

    // freeze with empty history, R9 / R10
    los = 4'hF; cyc();
    check(mode == 2'd2, "R9", mode, 2);
    for (int i = 0; i < 20; i++) begin cw_valid = 1'b1; cw_in = 16'($urandom); cyc(); end
    cw_valid = 1'b0;
    check(cw_out == 16'd1088, "R10", cw_out, 1088);

    // R1: faults on three inputs, fourth clean
    los = 4'h0; fos = 4'h7; repeat (5) cyc();
    check(mode == 2'd0, "R1", mode, 0);
    los = 4'h3; fos = 4'hC; cyc();
    check(mode == 2'd2, "R1", mode, 2);
    los = 4'h0; fos = 4'h0; cyc();

    // R2: loss-only variant ignores fault flags
    fos_v = 2'b11; repeat (4) cyc();
    check(mode_v == 2'd0, "R2", mode_v, 0);
    los_v = 2'b11; cyc();
    check(mode_v != 2'd0, "R2", mode_v, 2);
    los_v = 2'b00; fos_v = 2'b00; cyc();

    // R4 clamp: codes 9 behave as 4, full ring window
    dc = 5'd9; ac = 5'd9; cyc();
    for (int i = 0; i < 31; i++) push(3000 + ((i < 24) ? i : 0));
    check(hv == 1'b0, "R4", hv, 0);
    push(100);
    check(hv == 1'b1, "R4", hv, 1);
    for (int i = 32; i < 40; i++) push(100);
    los = 4'hF; cyc();
    check(mode == 2'd1, "R4", mode, 1);
    repeat (700) cyc();
    check(cw_out == 16'd3015, "R6", cw_out, 3015);
    los = 4'h0; cyc();

    // R5: code change clears history
    dc = 5'd1; ac = 5'd1; cyc();
    for (int i = 0; i < 4; i++) push(400 + i);
    check(hv == 1'b1, "R5", hv, 1);
    ac = 5'd2; cyc();
    check(hv == 1'b0, "R5", hv, 0);

    // constrained random run against the model
    for (int n = 0; n < 5000; n++) begin
      if ($urandom % 60 == 0) lost = !lost;
      if ($urandom % 200 == 0) begin dc = 5'($urandom % 7); ac = 5'($urandom % 7); end
      for (int i = 0; i < 4; i++) begin
        rv = int'($urandom % 4);
        if (lost && rv == 0) rv = 1 + int'($urandom % 3);
        los[i] = rv[0]; fos[i] = rv[1];
      end
      if (!lost) begin last = int'($urandom % 4); los[last] = 1'b0; fos[last] = 1'b0; end
      cw_valid = ($urandom % 3) != 0;
      cw_in = 16'($urandom);
      cyc();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule